// File: doc/BRIEF.md
# Serial Acknowledge Interrupt Priority Chain

This block settles which of several interrupting devices is serviced first. It does not use a central encoder. Each device owns one stage in a chain of identical stages. A stage remembers a request from its device in a request flag. The flag stays set until the device has been serviced, even if the device request was only a single-cycle pulse. All the flags are ORed into one interrupt line toward the processor.

When the processor answers with an acknowledge, that acknowledge enters the first stage and ripples down the chain. A stage with no pending flag hands the acknowledge on to the next stage. A stage with a pending flag keeps the acknowledge, stops it from going further, and puts its own vector address on a shared vector bus. Position in the chain therefore fixes priority: stage 0, the stage nearest the processor, wins over every later stage.

On the clock edge that ends the serviced cycle, the winning stage drops its flag, so that the next pending stage can win the following acknowledge. The shared bus is built as a multiplexer driven by the one-hot stage enables. It reads zero when no stage is enabled. Each stage's vector address is set by a parameter.

Top module: `irq_chain_top`

## Requirements
- R1: When the acknowledge is high and several flags are pending, only the lowest-numbered pending stage is enabled. Stage 0 outranks every other stage.
- R2: While the acknowledge input is low, no stage enable is high and the vector bus reads zero, whatever flags are pending.
- R3: A stage whose flag is clear passes the acknowledge on. A pending stage that sits behind non-pending stages is enabled when the acknowledge is high.
- R4: At most one bit of the stage-enable output is high in any cycle.
- R5: The vector bus carries the enabled stage's parameter vector. With the defaults these are stage 0 = 0x10, stage 1 = 0x24 and stage 2 = 0x38. The bus is all zeros when no stage is enabled.
- R6: The interrupt output is high exactly when at least one flag is set. A request raised in one cycle shows on the interrupt output after the next rising clock edge.
- R7: A device request lasting a single cycle sets its stage's flag. The flag stays set across any number of idle cycles until that stage is serviced.
- R8: A stage that is enabled while the acknowledge is high clears its flag on the following clock edge. A request from that same stage in that same cycle is not latched. Other stages latch normally.
- R9: Asynchronous active-low reset clears every flag. After reset the interrupt output, the enables and the vector bus are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NUM_STAGES | Request from each device; bit i belongs to stage i |
| cpu_ack | input | 1 | Acknowledge from the processor, feeds stage 0 |
| cpu_irq | output | 1 | Combined interrupt request to the processor |
| vec_en | output | NUM_STAGES | One-hot enable of the stage that owns the bus |
| vec_bus | output | VEC_W | Vector address of the winning stage, zero if none |

## Verification
The bench raises several requests at once and then acknowledges them one after another. A chain that ranked stages the wrong way, or let the acknowledge pass through a pending stage, would enable the wrong stage or two stages at once. It also drops a one-cycle request and leaves the chain idle for several cycles. A flag that did not hold its value would lower the interrupt too early. It sends a request from the same stage in the cycle that stage is being serviced; a design that let the set win over the clear would keep raising the interrupt. A random phase with frequent acknowledges then compares the enables, the vector bus and the interrupt line against a behavioural model on every cycle.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef struct packed {
        logic req;
    } stage_state_t;

endpackage

// File: rtl/irq_stage.sv
module irq_stage
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic pri_in,
    output logic pri_out,
    output logic vec_en,
    output logic req_flag
);

    stage_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        vec_en  = pri_in & st_q.req;
        pri_out = pri_in & ~st_q.req;
        // pri_in can only be high while the processor acknowledges,
        // so an enabled stage is a serviced stage
        if (vec_en)
            st_d.req = 1'b0;
        else if (dev_req)
            st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req_flag = st_q.req;

endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
    parameter int NUM_STAGES = 3,
    parameter int VEC_W      = 8,
    parameter logic [NUM_STAGES*VEC_W-1:0] VEC_TABLE = 24'h38_24_10
) (
    input  logic [NUM_STAGES-1:0] sel,
    output logic [VEC_W-1:0]      bus_out
);

    logic [VEC_W-1:0] masked [NUM_STAGES];

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_mask
        assign masked[i] = sel[i] ? VEC_TABLE[i*VEC_W +: VEC_W] : '0;
    end

    always_comb begin
        bus_out = '0;
        for (int i = 0; i < NUM_STAGES; i++)
            bus_out = bus_out | masked[i];
    end

endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top #(
    parameter int NUM_STAGES = 3,
    parameter int VEC_W      = 8,
    parameter logic [NUM_STAGES*VEC_W-1:0] VEC_TABLE = 24'h38_24_10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] dev_req,
    input  logic                  cpu_ack,
    output logic                  cpu_irq,
    output logic [NUM_STAGES-1:0] vec_en,
    output logic [VEC_W-1:0]      vec_bus
);

    localparam int LINKS = NUM_STAGES + 1;

    logic [LINKS-1:0]      pri_link;
    logic [NUM_STAGES-1:0] flags;

    assign pri_link[0] = cpu_ack;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        irq_stage stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .dev_req  (dev_req[i]),
            .pri_in   (pri_link[i]),
            .pri_out  (pri_link[i+1]),
            .vec_en   (vec_en[i]),
            .req_flag (flags[i])
        );
    end

    assign cpu_irq = |flags;

    irq_vec_mux #(
        .NUM_STAGES (NUM_STAGES),
        .VEC_W      (VEC_W),
        .VEC_TABLE  (VEC_TABLE)
    ) mux_i (
        .sel     (vec_en),
        .bus_out (vec_bus)
    );

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int NUM_STAGES = 3,
    parameter int VEC_W      = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STAGES-1:0] dev_req,
    input logic                  cpu_ack,
    input logic                  cpu_irq,
    input logic [NUM_STAGES-1:0] vec_en,
    input logic [VEC_W-1:0]      vec_bus
);

    // R4
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_en));

    // R2
    no_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |-> (vec_en == '0 && vec_bus == '0));

    // R5
    empty_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en == '0) |-> (vec_bus == '0));

    // R3
    ack_reaches_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq) |-> (vec_en != '0));

    // R6
    req_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req != '0 && !cpu_ack) |=> cpu_irq);

    // R8
    served_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && vec_en != '0) |=> ((vec_en & $past(vec_en)) == '0));

endmodule

bind irq_chain_top irq_chain_chk #(
    .NUM_STAGES (NUM_STAGES),
    .VEC_W      (VEC_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_req (dev_req),
    .cpu_ack (cpu_ack),
    .cpu_irq (cpu_irq),
    .vec_en  (vec_en),
    .vec_bus (vec_bus)
);

// File: tb/irq_chain_top_tb_top.sv
module irq_chain_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic         cpu_ack = 1'b0;
    logic         cpu_irq;
    logic [N-1:0] vec_en;
    logic [W-1:0] vec_bus;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit [N-1:0] model = '0;
    logic [7:0] vec_ref [N] = '{8'h10, 8'h24, 8'h38};

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_top dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack),
        .cpu_irq(cpu_irq), .vec_en(vec_en), .vec_bus(vec_bus)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle, compare against the model, then advance the model
    task automatic step(input logic [N-1:0] r, input logic a, input string tag);
        int win;
        logic [N-1:0] en_exp;
        logic [7:0]   bus_exp;
        @(negedge clk);
        dev_req = r;
        cpu_ack = a;
        #1;
        win = -1;
        if (a)
            for (int i = N - 1; i >= 0; i--)
                if (model[i]) win = i;
        en_exp  = (win >= 0) ? (N'(1) << win) : '0;
        bus_exp = (win >= 0) ? vec_ref[win] : 8'h00;
        chk({tag, " R6 irq"}, int'(cpu_irq), int'(model != '0));
        chk({tag, a ? " R3 en" : " R2 en"}, int'(vec_en), int'(en_exp));
        chk({tag, " R5 bus"}, int'(vec_bus), int'(bus_exp));
        chk({tag, " R4 onehot"}, int'($countones(vec_en) <= 1), 1);
        model = (model & ~en_exp) | (r & ~en_exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (2) @(negedge clk);
        #1;
        // R9 reset state
        chk("R9 irq", int'(cpu_irq), 0);
        chk("R9 en", int'(vec_en), 0);
        chk("R9 bus", int'(vec_bus), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step('0, 1'b0, "R9");
        // R7 single-cycle pulse held across idle cycles
        step(3'b100, 1'b0, "R7");
        for (int k = 0; k < 4; k++) step('0, 1'b0, "R7");
        // R3 acknowledge passes stages 0 and 1 to reach stage 2
        step('0, 1'b1, "R3");
        // R8 flag gone on next edge
        step('0, 1'b0, "R8");
        // R1 three requests at once, served in chain order
        step(3'b111, 1'b0, "R1");
        step('0, 1'b1, "R1");
        step('0, 1'b1, "R1");
        step('0, 1'b1, "R1");
        step('0, 1'b1, "R1");
        // R2 pending flags but no acknowledge
        step(3'b011, 1'b0, "R2");
        for (int k = 0; k < 3; k++) step('0, 1'b0, "R2");
        // R8 same-stage request in serviced cycle is dropped, other latches
        step(3'b101, 1'b1, "R8");
        step('0, 1'b1, "R8");
        step('0, 1'b0, "R8");
        // held request with alternating acknowledge
        for (int k = 0; k < 6; k++) step(3'b010, k[0], "R8");
        step('0, 1'b1, "R8");
        // random phase
        lfsr = 8'hA5;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[2:0] & {N{lfsr[6]}}, lfsr[7] | lfsr[3], "RND");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule